// File: doc/BRIEF.md
# GPIB Talker Source Handshake

This block drives the talker half of the three-wire GPIB handshake for an instrument that returns words read from a CAMAC crate. It owns the DAV output and watches the listener's RFD and DAC lines. It also decides which byte of the latched 24-bit word sits on the bus. A byte is offered only when the device is addressed to talk, the controller has released ATN, the listener is ready, and the CAMAC cycle has latched its data. A short settling wait follows before DAV is raised.

Each DAC from the listener drops DAV and steps a byte sequencer. In normal mode the sequencer walks through the data bytes and then sends one response byte carrying the X and Q bits, flagged with EOI. In block mode the response byte is left out. After the last data byte is taken, the block asks for a fresh CAMAC cycle and starts the sequence again once new data has been latched. Bus direction and the enables for the two handshake halves follow the talk state.

Top module: `gpibTalkSource`

## Requirements
- R1: After reset, dav, eoi and cycleReq are low, and the first byte offered is data byte 0 of the sequence.
- R2: busDrive and sourceEn equal talkEn, and acceptorEn is its inverse.
- R3: dav stays low unless talkEn is high, atn is low, rfd is high, dac is low and dataLatched is high.
- R4: Once those conditions are first sampled true at a clock edge, dav rises on the (SETTLE_CYCLES+1)th edge counting that one, and only if the conditions hold throughout.
- R5: While dav is high it stays high until dac is sampled high; dav then falls at that edge and the sequencer moves on.
- R6: A word carries byteCount data bytes, with 0 treated as 1. In forward order, byte i is camacData[8i+7:8i]. When reverseOrder is high, the order is reversed.
- R7: In normal mode the data bytes are followed by the response byte {6'b0, qResp, xResp} (X in bit 0, Q in bit 1). eoi is high with dav for that byte only. After it is accepted, dav stays low until talk is dropped or atn is asserted.
- R8: In block mode no response byte is sent. Acceptance of the last data byte makes cycleReq high for exactly one cycle, starting at the same edge where dav falls, and the sequencer restarts at byte 0.
- R9: After a block-mode request, dav stays low until dataLatched has been seen low and then high again.
- R10: Dropping talkEn or raising atn takes dav low at the next edge and returns the sequencer to byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| talkEn | input | 1 | Device addressed to talk |
| atn | input | 1 | ATN line, high when asserted |
| rfd | input | 1 | Listener ready for data |
| dac | input | 1 | Listener data accepted |
| dataLatched | input | 1 | CAMAC word and X/Q are latched |
| blockMode | input | 1 | Skip response byte and re-request cycles |
| byteCount | input | 2 | Data bytes per word (0 means 1) |
| reverseOrder | input | 1 | Send the most significant byte first |
| camacData | input | 24 | Latched CAMAC read word |
| xResp | input | 1 | Latched X response |
| qResp | input | 1 | Latched Q response |
| busData | output | 8 | Byte currently offered on the bus |
| dav | output | 1 | Data valid |
| eoi | output | 1 | End marker, high with the response byte |
| busDrive | output | 1 | Bus buffers point outward |
| acceptorEn | output | 1 | Acceptor handshake enabled |
| sourceEn | output | 1 | Source handshake enabled |
| cycleReq | output | 1 | One-cycle request for a new CAMAC cycle |

## Verification
The assertions assume that byteCount, reverseOrder and blockMode stay fixed while talkEn is high. They also assume the listener raises dac only in answer to dav and holds it until dav falls. The stimulus changes the configuration only while talk is dropped. Its listener model raises dac only after seeing dav, with a random delay, and releases it one cycle later. The only exception is a single directed check that shows a high dac holding dav off.

// File: rtl/gpibTalkPkg.sv
package gpibTalkPkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_SETTLE,
    ST_DRIVE,
    ST_DONE,
    ST_REARM
  } talkState_t;

  // strobes from the handshake control to the byte datapath
  typedef struct packed {
    logic restart;
    logic advance;
    logic settleClr;
    logic settleInc;
  } seqStrobe_t;

endpackage

// File: rtl/gpibTalkDatapath.sv
module gpibTalkDatapath
  import gpibTalkPkg::*;
#(
  parameter int DATA_WIDTH    = 24,
  parameter int SETTLE_CYCLES = 2
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  seqStrobe_t                          stb,
  input  logic [$clog2(DATA_WIDTH/8+1)-1:0]   byteCount,
  input  logic                                reverseOrder,
  input  logic [DATA_WIDTH-1:0]               camacData,
  input  logic                                xResp,
  input  logic                                qResp,
  output logic [7:0]                          busData,
  output logic                                lastData,
  output logic                                isStatus,
  output logic                                settleDone
);

  localparam int NUM_LANES = DATA_WIDTH / 8;
  localparam int CNT_W     = $clog2(NUM_LANES + 1);
  localparam int SET_W     = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES + 1);

  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] nBytes;
  logic [CNT_W-1:0] pos;
  logic [SET_W-1:0] settleCnt;
  logic [7:0]       lane [NUM_LANES];
  logic [7:0]       dataByte;

  genvar g;
  generate
    for (g = 0; g < NUM_LANES; g++) begin : gLane
      assign lane[g] = camacData[g*8 +: 8];
    end
  endgenerate

  always_comb begin
    if (byteCount == '0)
      nBytes = CNT_W'(1);
    else if (int'(byteCount) > NUM_LANES)
      nBytes = CNT_W'(NUM_LANES);
    else
      nBytes = byteCount;
  end

  assign lastData = (idx == nBytes - CNT_W'(1));
  assign isStatus = (idx == nBytes);
  assign pos      = reverseOrder ? (nBytes - CNT_W'(1) - idx) : idx;

  always_comb begin
    dataByte = '0;
    for (int k = 0; k < NUM_LANES; k++)
      if (pos == CNT_W'(k)) dataByte = lane[k];
  end

  assign busData = isStatus ? {6'b0, qResp, xResp} : dataByte;

  always_ff @(posedge clk) begin
    if (!rstN)               idx <= '0;
    else if (stb.restart)    idx <= '0;
    else if (stb.advance)    idx <= idx + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)               settleCnt <= '0;
    else if (stb.settleClr)  settleCnt <= '0;
    else if (stb.settleInc)  settleCnt <= settleCnt + SET_W'(1);
  end

  assign settleDone = (settleCnt == SET_W'(SETTLE_CYCLES - 1));

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    idx <= nBytes);                                             // R6

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> idx == '0);                                 // R10

endmodule

// File: rtl/gpibTalkControl.sv
module gpibTalkControl
  import gpibTalkPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       talkEn,
  input  logic       atn,
  input  logic       rfd,
  input  logic       dac,
  input  logic       dataLatched,
  input  logic       blockMode,
  input  logic       lastData,
  input  logic       isStatus,
  input  logic       settleDone,
  output seqStrobe_t stb,
  output logic       dav,
  output logic       eoi,
  output logic       cycleReq
);

  talkState_t state, nextState;
  logic active;
  logic ready;
  logic reqPulse;

  assign active = talkEn && !atn;
  assign ready  = active && rfd && !dac && dataLatched;

  always_comb begin
    nextState = state;
    stb       = '0;
    reqPulse  = 1'b0;
    if (!active) begin
      nextState   = ST_WAIT;
      stb.restart = 1'b1;
    end else begin
      unique case (state)
        ST_WAIT: begin
          if (ready) begin
            stb.settleClr = 1'b1;
            nextState     = ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (!ready)          nextState     = ST_WAIT;
          else if (settleDone) nextState     = ST_DRIVE;
          else                 stb.settleInc = 1'b1;
        end
        ST_DRIVE: begin
          if (dac) begin
            if (isStatus) begin
              nextState = ST_DONE;
            end else if (blockMode && lastData) begin
              stb.restart = 1'b1;
              reqPulse    = 1'b1;
              nextState   = ST_REARM;
            end else begin
              stb.advance = 1'b1;
              nextState   = ST_WAIT;
            end
          end
        end
        ST_DONE:  nextState = ST_DONE;
        ST_REARM: if (!dataLatched) nextState = ST_WAIT;
        default:  nextState = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_WAIT;
      cycleReq <= 1'b0;
    end else begin
      state    <= nextState;
      cycleReq <= reqPulse;
    end
  end

  assign dav = (state == ST_DRIVE);
  assign eoi = dav && isStatus;

  AST_DAV_SETTLED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dav) |-> $past(settleDone) && $past(ready));          // R4

  AST_DAV_NEEDS_TALK: assert property (@(posedge clk) disable iff (!rstN)
    dav |-> $past(active));                                     // R3

  AST_DAC_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    dav && dac && active |=> !dav);                             // R5

  AST_ABORT_DROPS_DAV: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> !dav);                                          // R10

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cycleReq |=> !cycleReq);                                    // R8

  AST_REQ_IN_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    cycleReq |-> $past(blockMode) && $past(dac));               // R8

  AST_EOI_NOT_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    eoi |-> !blockMode);                                        // R7

endmodule

// File: rtl/gpibTalkSource.sv
module gpibTalkSource
  import gpibTalkPkg::*;
#(
  parameter int DATA_WIDTH    = 24,
  parameter int SETTLE_CYCLES = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              talkEn,
  input  logic                              atn,
  input  logic                              rfd,
  input  logic                              dac,
  input  logic                              dataLatched,
  input  logic                              blockMode,
  input  logic [$clog2(DATA_WIDTH/8+1)-1:0] byteCount,
  input  logic                              reverseOrder,
  input  logic [DATA_WIDTH-1:0]             camacData,
  input  logic                              xResp,
  input  logic                              qResp,
  output logic [7:0]                        busData,
  output logic                              dav,
  output logic                              eoi,
  output logic                              busDrive,
  output logic                              acceptorEn,
  output logic                              sourceEn,
  output logic                              cycleReq
);

  seqStrobe_t stb;
  logic lastData;
  logic isStatus;
  logic settleDone;

  assign busDrive   = talkEn;
  assign sourceEn   = talkEn;
  assign acceptorEn = !talkEn;

  gpibTalkControl u_control (
    .clk         (clk),
    .rstN        (rstN),
    .talkEn      (talkEn),
    .atn         (atn),
    .rfd         (rfd),
    .dac         (dac),
    .dataLatched (dataLatched),
    .blockMode   (blockMode),
    .lastData    (lastData),
    .isStatus    (isStatus),
    .settleDone  (settleDone),
    .stb         (stb),
    .dav         (dav),
    .eoi         (eoi),
    .cycleReq    (cycleReq)
  );

  gpibTalkDatapath #(
    .DATA_WIDTH    (DATA_WIDTH),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .byteCount    (byteCount),
    .reverseOrder (reverseOrder),
    .camacData    (camacData),
    .xResp        (xResp),
    .qResp        (qResp),
    .busData      (busData),
    .lastData     (lastData),
    .isStatus     (isStatus),
    .settleDone   (settleDone)
  );

  AST_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
    busDrive != acceptorEn);                                    // R2

endmodule

// File: tb/gpibTalkSource_bench.sv
`timescale 1ns/1ps
module gpibTalkSource_bench;

  localparam int SETTLE = 2;
  localparam real CLK_NS = 4.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic talkEn = 0, atn = 0, rfd = 0, dac = 0, dataLatched = 0;
  logic blockMode = 0, reverseOrder = 0, xResp = 0, qResp = 0;
  logic [1:0]  byteCount = 2'd1;
  logic [23:0] camacData = '0;
  logic [7:0]  busData;
  logic dav, eoi, busDrive, acceptorEn, sourceEn, cycleReq;

  int checks = 0;
  int errors = 0;
  int seedDummy;

  always #(CLK_NS/2) clk = ~clk;

  gpibTalkSource #(.DATA_WIDTH(24), .SETTLE_CYCLES(SETTLE)) u_gpibTalkSource (
    .clk(clk), .rstN(rstN), .talkEn(talkEn), .atn(atn), .rfd(rfd), .dac(dac),
    .dataLatched(dataLatched), .blockMode(blockMode), .byteCount(byteCount),
    .reverseOrder(reverseOrder), .camacData(camacData), .xResp(xResp),
    .qResp(qResp), .busData(busData), .dav(dav), .eoi(eoi), .busDrive(busDrive),
    .acceptorEn(acceptorEn), .sourceEn(sourceEn), .cycleReq(cycleReq)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input logic [23:0] d, input logic [1:0] c,
                                         input logic rev, input int i);
    int n;
    int p;
    n = (c == 2'd0) ? 1 : int'(c);
    p = rev ? (n - 1 - i) : i;
    return d[p*8 +: 8];
  endfunction

  function automatic int nOf(input logic [1:0] c);
    return (c == 2'd0) ? 1 : int'(c);
  endfunction

  task automatic waitDav(output bit ok);
    ok = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (dav) begin ok = 1; break; end
    end
  endtask

  task automatic takeByte(input logic [7:0] expData, input logic expEoi,
                          input logic expReq, input string tag);
    bit ok;
    int d;
    waitDav(ok);
    check(ok, "R3 dav never rose", 32'(ok), 1);
    if (!ok) return;
    check(busData == expData, tag, busData, expData);
    check(eoi == expEoi, "R7 eoi flag", eoi, expEoi);
    rfd = 0;
    d = $urandom_range(0, 3);
    repeat (d) @(negedge clk);
    check(dav == 1'b1, "R5 dav held before dac", dav, 1);
    dac = 1;
    @(negedge clk);
    check(dav == 1'b0, "R5 dav released on dac", dav, 0);
    check(cycleReq == expReq, "R8 cycleReq at acceptance", cycleReq, expReq);
    dac = 0;
    @(negedge clk);
    if (expReq) check(cycleReq == 1'b0, "R8 cycleReq one cycle", cycleReq, 0);
    rfd = 1;
  endtask

  task automatic startTalk(input logic [23:0] d, input logic [1:0] c, input logic rev,
                           input logic x, input logic q, input logic blk);
    camacData = d; byteCount = c; reverseOrder = rev;
    xResp = x; qResp = q; blockMode = blk;
    atn = 0; dac = 0; rfd = 1; dataLatched = 1; talkEn = 1;
  endtask

  task automatic stopTalk();
    talkEn = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runTransfer(input logic [23:0] d0, input logic [1:0] c, input logic rev,
                             input logic x, input logic q, input logic blk, input int words);
    logic [23:0] d;
    int sawDav;
    d = d0;
    startTalk(d, c, rev, x, q, blk);
    for (int w = 0; w < words; w++) begin
      for (int i = 0; i < nOf(c); i++)
        takeByte(expByte(d, c, rev, i), 1'b0, blk && (i == nOf(c) - 1), "R6 data byte");
      if (blk) begin
        sawDav = 0;
        repeat (4) begin @(negedge clk); if (dav) sawDav++; end
        check(sawDav == 0, "R9 no dav before relatch", sawDav, 0);
        dataLatched = 0;
        @(negedge clk);
        d = $urandom();
        camacData = d;
        dataLatched = 1;
      end else begin
        takeByte({6'b0, q, x}, 1'b1, 1'b0, "R7 response byte");
        sawDav = 0;
        repeat (8) begin @(negedge clk); if (dav) sawDav++; end
        check(sawDav == 0, "R7 silent after response", sawDav, 0);
        break;
      end
    end
    stopTalk();
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    int sawDav;
    bit ok;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check(dav == 0 && eoi == 0 && cycleReq == 0, "R1 reset outputs",
          {29'b0, dav, eoi, cycleReq}, 0);
    rstN = 1;
    @(negedge clk);

    // R2 direction
    check(busDrive == 0 && sourceEn == 0 && acceptorEn == 1, "R2 idle direction",
          {29'b0, busDrive, sourceEn, acceptorEn}, 1);
    talkEn = 1; atn = 1;
    @(negedge clk);
    check(busDrive == 1 && sourceEn == 1 && acceptorEn == 0, "R2 talk direction",
          {29'b0, busDrive, sourceEn, acceptorEn}, 6);

    // R3 each missing condition holds dav off
    camacData = 24'hC3B2A1; byteCount = 2'd3; blockMode = 0; reverseOrder = 0;
    rfd = 1; dataLatched = 1; dac = 0;
    sawDav = 0; repeat (8) begin @(negedge clk); if (dav) sawDav++; end
    check(sawDav == 0, "R3 atn asserted", sawDav, 0);
    atn = 0; dataLatched = 0;
    sawDav = 0; repeat (8) begin @(negedge clk); if (dav) sawDav++; end
    check(sawDav == 0, "R3 not latched", sawDav, 0);
    dataLatched = 1; rfd = 0;
    sawDav = 0; repeat (8) begin @(negedge clk); if (dav) sawDav++; end
    check(sawDav == 0, "R3 rfd low", sawDav, 0);
    rfd = 1; dac = 1;
    sawDav = 0; repeat (8) begin @(negedge clk); if (dav) sawDav++; end
    check(sawDav == 0, "R3 dac high", sawDav, 0);
    talkEn = 0; dac = 0;
    @(negedge clk);

    // R4 settle timing, R1 first byte after reset
    talkEn = 1; rfd = 0;
    repeat (3) @(negedge clk);
    rfd = 1;
    n = 0;
    for (int k = 1; k < 20; k++) begin
      @(negedge clk);
      if (dav) begin n = k; break; end
    end
    check(n == SETTLE + 1, "R4 settle edges", n, SETTLE + 1);
    check(busData == 8'hA1, "R1 first byte is byte 0", busData, 8'hA1);
    takeByte(8'hA1, 0, 0, "R6 byte 0");
    takeByte(8'hB2, 0, 0, "R6 byte 1");
    // R10 abort while offering byte 2
    waitDav(ok);
    check(ok && busData == 8'hC3, "R6 byte 2 offered", busData, 8'hC3);
    atn = 1;
    @(negedge clk);
    check(dav == 0, "R10 atn aborts", dav, 0);
    atn = 0;
    takeByte(8'hA1, 0, 0, "R10 restart at byte 0");
    stopTalk();

    // directed corners
    runTransfer(24'h123456, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1);  // R6 count 0 means 1
    runTransfer(24'h123456, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1);  // R6 reverse
    runTransfer(24'hABCDEF, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 2);  // R8 block
    runTransfer(24'h0F0F0F, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 3);  // R9 block single

    // R10 talk dropped mid byte
    startTalk(24'h776655, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    takeByte(8'h55, 0, 0, "R6 byte 0 before drop");
    waitDav(ok);
    talkEn = 0;
    @(negedge clk);
    check(dav == 0, "R10 talk drop aborts", dav, 0);
    talkEn = 1;
    takeByte(8'h55, 0, 0, "R10 restart after talk drop");
    stopTalk();

    // constrained random transfers
    for (int t = 0; t < 40; t++) begin
      logic blk;
      blk = 1'($urandom_range(0, 1));
      runTransfer(24'($urandom()), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), blk,
                  blk ? $urandom_range(1, 3) : 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule